// File: doc/BRIEF.md
# Snooping Coherence Controller for Private Caches

This block keeps the private caches of several agents coherent over one shared snooping bus. Each agent owns a small tag/state table. The table has one entry per address word and records whether the agent holds that word, and in which state: not present, exclusive or shared. Processor reads that hit are served locally. So are writes to exclusively held words. Any other access becomes a transaction on the shared bus. The bus has two commands: a read that fills a line, and an update that broadcasts a written value to every other holder and to memory.

Every agent watches every transaction issued by the other agents and raises its shared response when it holds the addressed word. An exclusive holder that sees another agent read its word does three things: it supplies its own copy, which may be newer than memory, it downgrades to shared, and memory takes the supplied value. A round-robin arbiter lets one requester drive the bus per cycle. A behavioural memory stub answers reads that no exclusive holder supplies. There is no invalidation: a word stays cached once it has been filled.

Top module: `coh_snoop_sys`

## Requirements
- R1: After reset every table entry is not present, no bus transaction is driven, no done pulse is raised, and memory word x holds the value x.
- R2: A read of a not-present word issues exactly one bus read (bus_cmd_o = 0). The word fills as exclusive when no other agent raises the shared response, and as shared otherwise. The requester returns the bus data.
- R3: A read of a cached word, or a write to an exclusive word, completes with no bus transaction. cpu_done_o rises in the cycle after the request is accepted.
- R4: A write to a shared word issues exactly one bus update (bus_cmd_o = 1) that carries the new data. Every other holder and memory take that data. The writer ends shared when the shared response is high, and exclusive otherwise.
- R5: A non-owning agent that holds the addressed word raises the shared response on any transaction. An exclusive holder that sees a bus read supplies its copy as the bus data and moves to shared. At most one agent supplies at a time.
- R6: A write to a not-present word issues a bus read and then a bus update, in that order. It ends in the state given by the shared response to the update.
- R7: At most one agent is granted per cycle, and only an agent that requests. After a grant, the search for the next grant starts at the agent after the one just granted (round robin, starting at agent 0 after reset).
- R8: A processor request whose address equals that of a transaction driven by another agent in the same cycle is not accepted in that cycle. It is accepted one cycle later, against the updated state.
- R9: After any write completes, a read of that address by any agent returns the written value.
- R10: bus_owner_o carries the index of the granted agent, and bus_data_o carries the fill data on a read and the written data on an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | N_AGENTS | Per-agent request, held until done |
| cpu_we_i | input | N_AGENTS | Per-agent write enable |
| cpu_addr_i | input | N_AGENTS*ADDR_W | Per-agent word address |
| cpu_wdata_i | input | N_AGENTS*DATA_W | Per-agent write data |
| cpu_done_o | output | N_AGENTS | One-cycle completion pulse |
| cpu_rdata_o | output | N_AGENTS*DATA_W | Read data, valid with done |
| bus_valid_o | output | 1 | A transaction occupies the bus this cycle |
| bus_owner_o | output | OWN_W | Index of the granted agent |
| bus_cmd_o | output | 1 | 0 = read, 1 = update |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_data_o | output | DATA_W | Fill data on read, written data on update |
| bus_shared_o | output | 1 | OR of the snoop shared responses |

## Verification
The bench goes after four corner cases.

The first is a write to an exclusively held word. A controller that forgets its ownership would put an update on the bus, while one that treats a shared word as exclusive would leave stale copies behind. The first error shows as an unexpected bus cycle and the second as a wrong read value.

The second is a read of a word that another agent modified silently. If the exclusive holder fails to supply its copy, the reader returns the old memory value.

The third is three agents requesting in the same cycle after a prior grant has moved the round-robin pointer. A fixed-priority arbiter shows up there as the wrong owner sequence.

The fourth is a local write that lands in the same cycle as another agent's read of that word. Without the deferral, the write completes silently as exclusive, no update follows, and the reader keeps the old value.

A long pseudo-random sweep checks every bus cycle count, shared response and returned value against an arithmetic model of the states.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LINE_NP = 2'd0,
    LINE_EX = 2'd1,
    LINE_SH = 2'd2
  } line_st_e;

  typedef enum logic {
    CMD_RD  = 1'b0,
    CMD_UPD = 1'b1
  } bus_cmd_e;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_RD   = 2'd1,
    AG_UPD  = 2'd2,
    AG_RESP = 2'd3
  } ag_fsm_e;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N_AGENTS = 3,
  localparam int OWN_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] req_i,
  output logic [N_AGENTS-1:0] gnt_o
);
  logic [OWN_W-1:0] ptr_q;
  logic [OWN_W-1:0] win;
  logic             any;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    any   = 1'b0;
    for (int k = 0; k < N_AGENTS; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N_AGENTS) idx = idx - N_AGENTS;
      if (!any && req_i[idx]) begin
        any        = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = OWN_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (any) ptr_q <= (int'(win) == N_AGENTS - 1) ? '0 : win + OWN_W'(1);
  end

  p_one_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_idle_when_asked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/coh_mem_stub.sv
module coh_mem_stub #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i);
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/coh_agent.sv
module coh_agent
  import coh_pkg::*;
#(
  parameter int ID       = 0,
  parameter int N_AGENTS = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  localparam int OWN_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
  localparam int N_LINES = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              own_cmd_o,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic [DATA_W-1:0] own_wdata_o,
  input  logic              gnt_i,
  input  logic              bus_valid_i,
  input  logic [OWN_W-1:0]  bus_owner_i,
  input  logic              bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_shared_i,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] supply_data_o
);
  line_st_e          st_q   [N_LINES];
  logic [DATA_W-1:0] data_q [N_LINES];
  ag_fsm_e           fsm_q;
  logic              op_we_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic     foreign, snoop_hit, block, accept;
  line_st_e cpu_st, snp_st;

  assign cpu_st    = st_q[cpu_addr_i];
  assign snp_st    = st_q[bus_addr_i];
  assign foreign   = bus_valid_i && (bus_owner_i != OWN_W'(ID));
  assign snoop_hit = foreign && (snp_st != LINE_NP);
  // snoop wins over a local access to the same word
  assign block     = foreign && (bus_addr_i == cpu_addr_i);
  assign accept    = (fsm_q == AG_IDLE) && cpu_req_i && !block;

  assign shared_o      = snoop_hit;
  assign supply_o      = snoop_hit && (bus_cmd_i == CMD_RD) && (snp_st == LINE_EX);
  assign supply_data_o = supply_o ? data_q[bus_addr_i] : '0;

  assign bus_req_o   = (fsm_q == AG_RD) || (fsm_q == AG_UPD);
  assign own_cmd_o   = (fsm_q == AG_UPD);
  assign own_addr_o  = op_addr_q;
  assign own_wdata_o = op_wdata_q;
  assign cpu_done_o  = (fsm_q == AG_RESP);
  assign cpu_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LINES; i++) begin
        st_q[i]   <= LINE_NP;
        data_q[i] <= '0;
      end
      fsm_q      <= AG_IDLE;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rdata_q    <= '0;
    end else begin
      if (snoop_hit) begin
        if (bus_cmd_i == CMD_UPD) begin
          data_q[bus_addr_i] <= bus_data_i;
          st_q[bus_addr_i]   <= LINE_SH;
        end else if (snp_st == LINE_EX) begin
          st_q[bus_addr_i] <= LINE_SH;
        end
      end
      unique case (fsm_q)
        AG_IDLE: if (accept) begin
          op_we_q    <= cpu_we_i;
          op_addr_q  <= cpu_addr_i;
          op_wdata_q <= cpu_wdata_i;
          if (cpu_st == LINE_NP) begin
            fsm_q <= AG_RD;
          end else if (!cpu_we_i) begin
            rdata_q <= data_q[cpu_addr_i];
            fsm_q   <= AG_RESP;
          end else if (cpu_st == LINE_EX) begin
            data_q[cpu_addr_i] <= cpu_wdata_i;
            fsm_q              <= AG_RESP;
          end else begin
            fsm_q <= AG_UPD;
          end
        end
        AG_RD: if (gnt_i) begin
          data_q[op_addr_q] <= bus_data_i;
          st_q[op_addr_q]   <= bus_shared_i ? LINE_SH : LINE_EX;
          if (op_we_q) begin
            fsm_q <= AG_UPD;
          end else begin
            rdata_q <= bus_data_i;
            fsm_q   <= AG_RESP;
          end
        end
        AG_UPD: if (gnt_i) begin
          data_q[op_addr_q] <= op_wdata_q;
          st_q[op_addr_q]   <= bus_shared_i ? LINE_SH : LINE_EX;
          fsm_q             <= AG_RESP;
        end
        AG_RESP: fsm_q <= AG_IDLE;
        default: fsm_q <= AG_IDLE;
      endcase
    end
  end

  p_local_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cpu_st != LINE_NP && (!cpu_we_i || cpu_st == LINE_EX))
      |=> (cpu_done_o && !bus_req_o));
  p_downgrade_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit && bus_cmd_i == CMD_RD && snp_st == LINE_EX)
      |=> (st_q[$past(bus_addr_i)] == LINE_SH));
  p_copy_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit && bus_cmd_i == CMD_UPD)
      |=> (data_q[$past(bus_addr_i)] == $past(bus_data_i)));
  p_defer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == AG_IDLE && cpu_req_i && block) |=> (fsm_q == AG_IDLE));
  p_miss_to_update_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == AG_RD && gnt_i && op_we_q) |=> (fsm_q == AG_UPD));
endmodule

// File: rtl/coh_snoop_sys.sv
module coh_snoop_sys
  import coh_pkg::*;
#(
  parameter int N_AGENTS = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  localparam int OWN_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_AGENTS-1:0]          cpu_req_i,
  input  logic [N_AGENTS-1:0]          cpu_we_i,
  input  logic [N_AGENTS*ADDR_W-1:0]   cpu_addr_i,
  input  logic [N_AGENTS*DATA_W-1:0]   cpu_wdata_i,
  output logic [N_AGENTS-1:0]          cpu_done_o,
  output logic [N_AGENTS*DATA_W-1:0]   cpu_rdata_o,
  output logic                         bus_valid_o,
  output logic [OWN_W-1:0]             bus_owner_o,
  output logic                         bus_cmd_o,
  output logic [ADDR_W-1:0]            bus_addr_o,
  output logic [DATA_W-1:0]            bus_data_o,
  output logic                         bus_shared_o
);
  logic [N_AGENTS-1:0] bus_req, gnt, own_cmd, shared_v, supply_v;
  logic [ADDR_W-1:0]   own_addr  [N_AGENTS];
  logic [DATA_W-1:0]   own_wdata [N_AGENTS];
  logic [DATA_W-1:0]   supply_d  [N_AGENTS];

  logic              bus_valid, bus_cmd, bus_shared;
  logic [OWN_W-1:0]  bus_owner;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_data, supply_or, mem_rdata;

  coh_rr_arb #(.N_AGENTS(N_AGENTS)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (bus_req),
    .gnt_o (gnt)
  );

  always_comb begin
    bus_owner = '0;
    bus_cmd   = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    supply_or = '0;
    for (int k = 0; k < N_AGENTS; k++) begin
      if (gnt[k]) begin
        bus_owner = OWN_W'(k);
        bus_cmd   = own_cmd[k];
        bus_addr  = own_addr[k];
        bus_wdata = own_wdata[k];
      end
      supply_or = supply_or | supply_d[k];
    end
  end

  assign bus_valid  = |gnt;
  assign bus_shared = |shared_v;
  assign bus_data   = (bus_cmd == CMD_UPD) ? bus_wdata :
                      ((|supply_v) ? supply_or : mem_rdata);

  coh_mem_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr),
    .rdata_o(mem_rdata),
    .we_i   (bus_valid),
    .wdata_i(bus_data)
  );

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    coh_agent #(
      .ID      (g),
      .N_AGENTS(N_AGENTS),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
    ) u_agent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cpu_req_i    (cpu_req_i[g]),
      .cpu_we_i     (cpu_we_i[g]),
      .cpu_addr_i   (cpu_addr_i[g*ADDR_W +: ADDR_W]),
      .cpu_wdata_i  (cpu_wdata_i[g*DATA_W +: DATA_W]),
      .cpu_done_o   (cpu_done_o[g]),
      .cpu_rdata_o  (cpu_rdata_o[g*DATA_W +: DATA_W]),
      .bus_req_o    (bus_req[g]),
      .own_cmd_o    (own_cmd[g]),
      .own_addr_o   (own_addr[g]),
      .own_wdata_o  (own_wdata[g]),
      .gnt_i        (gnt[g]),
      .bus_valid_i  (bus_valid),
      .bus_owner_i  (bus_owner),
      .bus_cmd_i    (bus_cmd),
      .bus_addr_i   (bus_addr),
      .bus_data_i   (bus_data),
      .bus_shared_i (bus_shared),
      .shared_o     (shared_v[g]),
      .supply_o     (supply_v[g]),
      .supply_data_o(supply_d[g])
    );
  end

  assign bus_valid_o  = bus_valid;
  assign bus_owner_o  = bus_owner;
  assign bus_cmd_o    = bus_cmd;
  assign bus_addr_o   = bus_addr;
  assign bus_data_o   = bus_data;
  assign bus_shared_o = bus_shared;

  p_single_supplier_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(supply_v));
  p_owner_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid |-> ((shared_v & gnt) == '0));
  p_supply_only_on_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|supply_v) |-> (bus_valid && bus_cmd == CMD_RD));
endmodule

// File: tb/coh_snoop_sys_bench.sv
`timescale 1ns/1ps
module coh_snoop_sys_bench;
  localparam int N  = 3;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int OW = 2;
  localparam int NL = 1 << AW;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N-1:0]      req = '0, we = '0;
  logic [N*AW-1:0]   addr = '0;
  logic [N*DW-1:0]   wdata = '0;
  logic [N-1:0]      done;
  logic [N*DW-1:0]   rdata;
  logic              bus_valid, bus_cmd, bus_shared;
  logic [OW-1:0]     bus_owner;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int st_m [N][NL];   // 0 not present, 1 exclusive, 2 shared
  int val_m [NL];

  always #5 clk_i = ~clk_i;

  coh_snoop_sys #(.N_AGENTS(N), .ADDR_W(AW), .DATA_W(DW)) u_coh_snoop_sys (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_done_o(done), .cpu_rdata_o(rdata),
    .bus_valid_o(bus_valid), .bus_owner_o(bus_owner), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_data_o(bus_data), .bus_shared_o(bus_shared)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    req = '0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int a = 0; a < N; a++)
      for (int x = 0; x < NL; x++) st_m[a][x] = 0;
    for (int x = 0; x < NL; x++) val_m[x] = x;
  endtask

  function automatic bit others_hold(input int a, input int x);
    bit h = 0;
    for (int b = 0; b < N; b++) if (b != a && st_m[b][x] != 0) h = 1;
    return h;
  endfunction

  function automatic void others_read(input int a, input int x);
    for (int b = 0; b < N; b++) if (b != a && st_m[b][x] == 1) st_m[b][x] = 2;
  endfunction

  // one serial operation by agent a, checked against the state model
  task automatic do_op(input int a, input bit w, input int x, input int d);
    int rd_n = 0, up_n = 0, lat = 0, rd_sh = 0, up_sh = 0, got = 0;
    int exp_rd, exp_up; bit sh; bit fin = 0;
    sh = others_hold(a, x);
    exp_rd = (st_m[a][x] == 0) ? 1 : 0;
    exp_up = (w && st_m[a][x] != 1) ? 1 : 0;
    req[a] = 1'b1; we[a] = w;
    addr[a*AW +: AW] = AW'(x); wdata[a*DW +: DW] = DW'(d);
    for (int c = 0; c < 12 && !fin; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      lat++;
      if (bus_valid) begin
        chk(int'(bus_owner) == a, "R10", "bus owner", int'(bus_owner), a);
        chk(int'(bus_addr) == x, "R10", "bus address", int'(bus_addr), x);
        if (bus_cmd == 1'b0) begin
          rd_n++; rd_sh = int'(bus_shared);
          chk(int'(bus_data) == val_m[x], "R5", "fill data", int'(bus_data), val_m[x]);
          chk(up_n == 0, "R6", "read before update", up_n, 0);
        end else begin
          up_n++; up_sh = int'(bus_shared);
          chk(int'(bus_data) == (d & 255), "R4", "update data", int'(bus_data), d & 255);
        end
      end
      if (done[a]) begin
        fin = 1; got = int'(rdata[a*DW +: DW]);
        req[a] = 1'b0;
      end
    end
    chk(fin, "R3", "completion seen", int'(fin), 1);
    chk(rd_n == exp_rd, exp_up == 1 && exp_rd == 1 ? "R6" : "R2", "bus reads", rd_n, exp_rd);
    chk(up_n == exp_up, exp_up == 1 ? "R4" : "R3", "bus updates", up_n, exp_up);
    if (exp_rd == 1) chk(rd_sh == int'(sh), "R5", "shared on read", rd_sh, int'(sh));
    if (exp_up == 1) chk(up_sh == int'(sh), "R5", "shared on update", up_sh, int'(sh));
    if (exp_rd == 0 && exp_up == 0) chk(lat == 1, "R3", "local latency", lat, 1);
    if (!w) chk(got == val_m[x], "R9", "read value", got, val_m[x]);
    if (exp_rd == 1) others_read(a, x);
    if (exp_rd == 1 || exp_up == 1) st_m[a][x] = sh ? 2 : 1;
    if (w) val_m[x] = d & 255;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int lfsr;
    int own_seq [3];
    int nseen;
    logic [N-1:0] left;
    do_reset();
    // R1: quiet after reset
    @(negedge clk_i);
    chk(bus_valid == 1'b0, "R1", "bus idle", int'(bus_valid), 0);
    chk(done == '0, "R1", "no done", int'(done), 0);
    do_op(0, 0, 2, 0);  // miss, reset value 2, fills exclusive
    do_op(0, 1, 2, 8'h3C);  // exclusive write: silent
    do_op(1, 0, 2, 0);  // supplied by agent 0, both shared
    do_op(2, 0, 2, 0);
    do_op(1, 1, 2, 8'h77);  // broadcast
    do_op(2, 1, 7, 8'h19);  // write miss, nobody else: exclusive
    do_op(2, 1, 7, 8'h1A);  // silent

    // R7: round robin after pointer moved by a grant to agent 1
    do_reset();
    do_op(1, 0, 0, 0);
    req = '0; we = '0;
    for (int a = 0; a < N; a++) addr[a*AW +: AW] = AW'(3 + a);
    req = '1; left = '1; nseen = 0;
    for (int c = 0; c < 12 && left != '0; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (bus_valid && nseen < 3) begin own_seq[nseen] = int'(bus_owner); nseen++; end
      for (int a = 0; a < N; a++) if (done[a] && left[a]) begin
        chk(int'(rdata[a*DW +: DW]) == 3 + a, "R2", "concurrent read value",
            int'(rdata[a*DW +: DW]), 3 + a);
        left[a] = 1'b0; req[a] = 1'b0;
        st_m[a][3 + a] = 1;
      end
    end
    chk(nseen == 3, "R7", "grant count", nseen, 3);
    chk(own_seq[0] == 2, "R7", "first owner", own_seq[0], 2);
    chk(own_seq[1] == 0, "R7", "second owner", own_seq[1], 0);
    chk(own_seq[2] == 1, "R7", "third owner", own_seq[2], 1);
    @(posedge clk_i); @(negedge clk_i);

    // R8: local write to an exclusive word collides with a foreign read
    do_op(0, 0, 6, 0);
    req[1] = 1'b1; we[1] = 1'b0; addr[1*AW +: AW] = AW'(6);
    @(posedge clk_i); @(negedge clk_i);
    chk(bus_valid && bus_owner == 2'd1 && bus_cmd == 1'b0, "R8", "foreign read on bus",
        int'(bus_owner), 1);
    req[0] = 1'b1; we[0] = 1'b1; addr[0 +: AW] = AW'(6); wdata[0 +: DW] = 8'hA5;
    @(posedge clk_i); @(negedge clk_i);
    chk(done[1] == 1'b1, "R8", "reader done", int'(done[1]), 1);
    chk(int'(rdata[DW +: DW]) == 6, "R5", "supplied old value", int'(rdata[DW +: DW]), 6);
    chk(done[0] == 1'b0, "R8", "write deferred", int'(done[0]), 0);
    req[1] = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk(bus_valid && bus_owner == 2'd0 && bus_cmd == 1'b1, "R8", "deferred write broadcasts",
        int'(bus_cmd), 1);
    chk(int'(bus_data) == 8'hA5, "R4", "deferred update data", int'(bus_data), 8'hA5);
    chk(bus_shared == 1'b1, "R5", "shared on update", int'(bus_shared), 1);
    @(posedge clk_i); @(negedge clk_i);
    chk(done[0] == 1'b1, "R8", "writer done", int'(done[0]), 1);
    req[0] = 1'b0;
    st_m[0][6] = 2; st_m[1][6] = 2; val_m[6] = 8'hA5;
    @(posedge clk_i); @(negedge clk_i);
    do_op(1, 0, 6, 0);  // R9: hit returns new value

    // pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int ag;
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
      ag = (lfsr >> 4) % N;
      do_op(ag, lfsr[0], (lfsr >> 1) & 7, (lfsr >> 8) & 255);
    end
    // R9: every agent sees every final value
    for (int x = 0; x < NL; x++)
      for (int a = 0; a < N; a++) do_op(a, 0, x, 0);
    finish_run();
  end
endmodule